// File: doc/BRIEF.md
# Infrared Carrier Demodulator with Edge Window

This block watches a receive line from an infrared detector and decides whether a modulated carrier is present. A programmable divider turns the reference clock into receive ticks, and the nominal carrier period is sixteen of those ticks. Each rising edge of the synchronized input is timed against the previous one. The edge is accepted only if it falls inside a tolerance window around sixteen ticks. The output is a clean envelope: mark (1) while accepted edges keep arriving, space (0) when they stop or arrive out of step.

A 2-bit window field chooses how far each side of the window reaches. Bit 0 widens the early side and bit 1 widens the late side. A demodulation enable chooses between this carrier detection and a plain pass-through of the synchronized input level. Typical use is to program the divider so that sixteen ticks match the expected carrier period, for example divider 93 for a 36 kHz carrier on a 54 MHz reference, and feed the envelope to a pulse-width timer.

Top module: `ir_carrier_demod`

## Requirements
- R1: A receive tick occurs once every (div_val + 1) clock cycles; with div_val = 0 every cycle is a tick.
- R2: With win_sel = 2'b00, a rising edge that comes 13 to 19 ticks after the previous rising edge is in window; edges at other spacings are not.
- R3: Setting win_sel bit 0 moves the early limit from 13 to 12 ticks, and leaves the late limit unchanged.
- R4: Setting win_sel bit 1 moves the late limit from 19 to 20 ticks, and leaves the early limit unchanged.
- R5: The input passes two synchronizer flops before rising-edge detection. After a space period, the first rising edge only arms the checker. env_out goes to 1 (mark) after the second consecutive in-window edge, 3 clock cycles after that input rise.
- R6: Once late-limit + 1 ticks pass with no rising edge, env_out returns to 0. For div_val = 0 and win_sel = 0, this is 23 cycles after the last input rise.
- R7: With demod_en = 0, env_out equals rx_in delayed by two cycles and the checker is cleared. After demod_en returns to 1, the first edge only arms again.
- R8: A rising edge outside the window drops env_out to space and becomes the new reference. The next edge in window with respect to it restores mark.
- R9: During and right after reset, env_out is 0 and the checker holds no reference edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| div_val | input | 16 | Tick divider; tick period is div_val + 1 clocks |
| win_sel | input | 2 | Bit 0: early side 4 ticks; bit 1: late side 4 ticks |
| demod_en | input | 1 | 1: carrier detection, 0: raw level pass-through |
| rx_in | input | 1 | Asynchronous receive line from the detector |
| env_out | output | 1 | Envelope, 1 = mark, 0 = space |

## Verification
The assertions assume that div_val and win_sel only change while the line is idle or the checker is cleared. Under that assumption, each measured gap is a whole number of ticks of a single divider setting. The assertions also take rx_in as a level that holds for at least one clock, so the synchronizer sees every rising edge. The stimulus changes configuration only after long idle gaps or while demodulation is disabled. It drives square waves whose edge spacing is an exact multiple of the tick period, so every gap maps to one known tick count.

// File: rtl/ir_demod_pkg.sv
package ir_demod_pkg;

    // Tick-domain constants
    localparam int NOM_TICKS  = 16;
    localparam int TOL_NARROW = 3;
    localparam int TOL_WIDE   = 4;
    localparam int GAP_W      = 6;
    localparam logic [GAP_W-1:0] GAP_MAX = '1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_LOCK  = 2'd2
    } trk_state_e;

    typedef struct packed {
        logic late_wide;   // bit 1
        logic early_wide;  // bit 0
    } win_cfg_t;

    function automatic logic [GAP_W-1:0] early_limit(input win_cfg_t w);
        int unsigned v;
        v = NOM_TICKS - (w.early_wide ? TOL_WIDE : TOL_NARROW);
        return GAP_W'(v);
    endfunction

    function automatic logic [GAP_W-1:0] late_limit(input win_cfg_t w);
        int unsigned v;
        v = NOM_TICKS + (w.late_wide ? TOL_WIDE : TOL_NARROW);
        return GAP_W'(v);
    endfunction

endpackage

// File: rtl/ir_tick_div.sv
module ir_tick_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == '0)
            cnt_q <= div_val;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    assign tick_o = (cnt_q == '0);

    // R1: a nonzero divider never yields ticks on consecutive cycles
    p_tick_spacing_r1: assert property (@(posedge clk) disable iff (rst)
        (tick_o && div_val != '0) |=> !tick_o);

endmodule

// File: rtl/ir_rx_sync.sv
module ir_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_raw,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= rx_raw;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= {sh_q[STAGES-2:0], rx_raw};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sh_q[STAGES-1];
    end

    assign level_o = sh_q[STAGES-1];
    assign rise_o  = sh_q[STAGES-1] & ~prev_q;

    // R5: a detected rise needs the raw line high STAGES cycles earlier
    p_rise_needs_input_r5: assert property (@(posedge clk) disable iff (rst)
        rise_o |-> $past(rx_raw, STAGES));

endmodule

// File: rtl/ir_period_check.sv
module ir_period_check
    import ir_demod_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en_i,
    input  logic     tick_i,
    input  logic     rise_i,
    input  win_cfg_t win_i,
    output logic     locked_o
);
    trk_state_e       st_q, st_d;
    logic [GAP_W-1:0] gap_q, gap_d, gap_inc;
    logic [GAP_W-1:0] lim_lo, lim_hi;
    logic             in_win, expired;

    assign lim_lo  = early_limit(win_i);
    assign lim_hi  = late_limit(win_i);
    assign gap_inc = (tick_i && gap_q != GAP_MAX) ? gap_q + 1'b1 : gap_q;
    assign in_win  = (gap_inc >= lim_lo) && (gap_inc <= lim_hi);
    assign expired = (gap_inc > lim_hi);

    always_comb begin
        st_d  = st_q;
        gap_d = gap_q;
        if (!en_i) begin
            st_d  = ST_IDLE;
            gap_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    gap_d = '0;
                    if (rise_i) st_d = ST_ARMED;
                end
                ST_ARMED, ST_LOCK: begin
                    if (rise_i) begin
                        st_d  = in_win ? ST_LOCK : ST_ARMED;
                        gap_d = '0;
                    end else if (expired) begin
                        st_d  = ST_IDLE;
                        gap_d = '0;
                    end else begin
                        gap_d = gap_inc;
                    end
                end
                default: begin
                    st_d  = ST_IDLE;
                    gap_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            gap_q <= '0;
        end else begin
            st_q  <= st_d;
            gap_q <= gap_d;
        end
    end

    assign locked_o = (st_q == ST_LOCK);

    // R5: mark is only entered from the armed state on an edge
    p_lock_from_armed_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> ($past(st_q) == ST_ARMED && $past(rise_i)));

    // R6: while locked the gap never exceeds the late limit
    p_gap_bound_r6: assert property (@(posedge clk) disable iff (rst)
        locked_o |-> (gap_q <= lim_hi));

    // R2: an early edge never leads to lock
    p_early_reject_r2: assert property (@(posedge clk) disable iff (rst)
        (en_i && rise_i && st_q != ST_IDLE && gap_inc < lim_lo) |=> st_q == ST_ARMED);

    // R7: disabling clears the checker
    p_disable_clears_r7: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> st_q == ST_IDLE);

endmodule

// File: rtl/ir_carrier_demod.sv
module ir_carrier_demod
    import ir_demod_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_val,
    input  logic [1:0]       win_sel,
    input  logic             demod_en,
    input  logic             rx_in,
    output logic             env_out
);
    logic     tick, rx_level, rx_rise, locked;
    win_cfg_t win_cfg;

    assign win_cfg = win_cfg_t'(win_sel);

    ir_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .div_val (div_val),
        .tick_o  (tick)
    );

    ir_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .rx_raw  (rx_in),
        .level_o (rx_level),
        .rise_o  (rx_rise)
    );

    ir_period_check u_chk (
        .clk      (clk),
        .rst      (rst),
        .en_i     (demod_en),
        .tick_i   (tick),
        .rise_i   (rx_rise),
        .win_i    (win_cfg),
        .locked_o (locked)
    );

    assign env_out = demod_en ? locked : rx_level;

    // R9: envelope is space in the first cycle after reset
    p_reset_space_r9: assert property (@(posedge clk)
        $past(rst) && demod_en |-> !env_out);

    // R5: with demodulation, mark can only rise after a detected edge
    p_mark_after_edge_r5: assert property (@(posedge clk) disable iff (rst)
        (demod_en && $past(demod_en) && $rose(env_out)) |-> $past(rx_rise));

endmodule

// File: tb/ir_carrier_demod_tb.sv
`timescale 1ns/1ps
module ir_carrier_demod_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] div_val;
    logic [1:0]  win_sel;
    logic        demod_en;
    logic        rx_in;
    logic        env_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    ir_carrier_demod dut_i (
        .clk(clk), .rst(rst), .div_val(div_val), .win_sel(win_sel),
        .demod_en(demod_en), .rx_in(rx_in), .env_out(env_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: env_out=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // n rising edges spaced p clocks apart; returns p clocks after last rise
    task automatic send(input int p, input int n);
        for (int i = 0; i < n; i++) begin
            rx_in = 1'b1;
            wait_n(p / 2);
            rx_in = 1'b0;
            wait_n(p - p / 2);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; div_val = '0; win_sel = 2'b00; demod_en = 1'b1; rx_in = 1'b0;
        wait_n(4);
        chk("R9 env during reset", env_out, 1'b0);
        rst = 1'b0;
        wait_n(1);
        chk("R9 env after reset", env_out, 1'b0);
        wait_n(5);

        // R2/R3/R4 sweep, div_val = 0 so one tick per clock
        for (int w = 0; w < 4; w++) begin
            for (int p = 10; p <= 22; p++) begin
                int lo, hi;
                lo = 13 - (w & 1);
                hi = 19 + ((w >> 1) & 1);
                win_sel = 2'(w);
                wait_n(30);
                send(p, 4);
                chk((w == 0) ? "R2 window sweep" : ((w & 1) ? "R3 early sweep" : "R4 late sweep"),
                    env_out, (p >= lo && p <= hi));
            end
        end

        // R5 arming and lock latency
        win_sel = 2'b00;
        wait_n(30);
        send(16, 1);
        chk("R5 first edge only arms", env_out, 1'b0);
        rx_in = 1'b1;
        wait_n(2);
        chk("R5 before lock latency", env_out, 1'b0);
        wait_n(1);
        chk("R5 mark 3 cycles after second edge", env_out, 1'b1);
        wait_n(5);
        rx_in = 1'b0;
        wait_n(8);

        // R6 exact timeout
        send(16, 3);
        chk("R6 locked before timeout", env_out, 1'b1);
        wait_n(6);
        chk("R6 still mark at cycle 22", env_out, 1'b1);
        wait_n(1);
        chk("R6 space at cycle 23", env_out, 1'b0);

        // R8 out-of-window edge drops mark, then relocks
        wait_n(30);
        send(16, 3);
        chk("R8 locked", env_out, 1'b1);
        send(8, 1);
        send(16, 1);
        chk("R8 early edge drops mark", env_out, 1'b0);
        send(16, 1);
        chk("R8 relock from new reference", env_out, 1'b1);

        // R7 pass-through and clear
        wait_n(30);
        send(16, 3);
        demod_en = 1'b0;
        rx_in = 1'b0;
        wait_n(4);
        chk("R7 raw low", env_out, 1'b0);
        rx_in = 1'b1;
        wait_n(1);
        chk("R7 raw delayed one cycle", env_out, 1'b0);
        wait_n(1);
        chk("R7 raw high after two cycles", env_out, 1'b1);
        rx_in = 1'b0;
        wait_n(2);
        chk("R7 raw low after two cycles", env_out, 1'b0);
        wait_n(3);
        demod_en = 1'b1;
        send(16, 1);
        chk("R7 re-enable only arms", env_out, 1'b0);
        send(16, 1);
        chk("R7 re-enable locks", env_out, 1'b1);

        // R1 divider: div_val = 2, three clocks per tick
        div_val = 16'd2;
        begin
            int pp[6]   = '{48, 66, 36, 36, 60, 60};
            int ww[6]   = '{0, 0, 0, 1, 2, 0};
            logic ex[6] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
            for (int k = 0; k < 6; k++) begin
                win_sel = 2'(ww[k]);
                wait_n(100);
                send(pp[k], 4);
                chk("R1 divided tick spacing", env_out, ex[k]);
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule